// File: doc/BRIEF.md
# Multi-Channel Summation Output Formatter

This block combines the sample streams of four transmit channels, plus an optional wideband sample stream, into a single output word. It then shapes that word for the output pins. A control word chooses the behaviour at run time. An over-range sum either wraps or saturates at full scale. The result is encoded as two's complement or as offset binary. The wideband stream can be left out of the sum. The channels can also be split across two output buses.

In single-output mode every channel, and the wideband sample when it is enabled, goes into the first bus, and the second bus is held at zero. In dual-output mode the first bus carries the lower half of the channels (A and B) plus the wideband sample when it is enabled. The second bus carries the upper half (C and D). Both buses are formatted the same way. The sums are formed with guard bits so that no intermediate result overflows, and both outputs are registered.

Top module: `chan_sum_formatter`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after it, both output buses are zero.
- R2: With the control word at 0x10, `dout_a` equals the sum of the four 18-bit signed channel samples (channel i in `ch_data[18*i+17:18*i]`), registered with exactly one clock of latency.
- R3: Control bit 4 low adds `wb_data` into the `dout_a` sum. Control bit 4 high leaves `wb_data` out, whatever its value.
- R4: Control bit 0 low wraps an over-range sum: the output is the low 18 bits of the exact two's-complement sum.
- R5: Control bit 0 high saturates the sum to the range +131071 to -131072 (0x1FFFF and 0x20000). Sums inside that range pass through unchanged.
- R6: Control bit 1 high gives offset binary: bit 17 of the final two's-complement result is inverted and the other bits are unchanged. Control bit 1 low leaves the result in two's complement.
- R7: Control bit 3 high enables dual output. `dout_a` carries channels A+B (plus the wideband sample when bit 4 is low) and `dout_b` carries channels C+D. Both buses obey bits 0 and 1.
- R8: Control bit 3 low drives `dout_b` to all zeros, one clock after the control word is applied.
- R9: Control bits 2, 5 and 6 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 7 | Mode control: bit0 clip, bit1 offset binary, bit3 dual output, bit4 wideband off |
| ch_data | input | 72 | Four signed 18-bit channel samples, channel A in the low bits |
| wb_data | input | 18 | Signed wideband sample |
| dout_a | output | 18 | First formatted output bus |
| dout_b | output | 18 | Second formatted output bus (zero unless dual output is on) |

## Verification
The bench drives all four channels at positive and negative full scale at the same time, in both overflow modes. A limiter that tests too few guard bits, or that swaps the saturation limits, then gives a wrong value or the wrong sign. Offset binary is checked together with clipping, which catches an encoder that inverts the bit before saturation instead of after it. Dual mode is switched on and off across cycles to show that the second bus clears one clock later and that the wideband sample stays on the first bus. Toggling the reserved bits, and running a long stretch of random control words against the behavioural model, exposes any decode that reads the wrong bit.

// File: rtl/sumfmt_pkg.sv
package sumfmt_pkg;
   localparam int CTRL_W    = 7;
   localparam int CB_CLIP   = 0;
   localparam int CB_OFFSET = 1;
   localparam int CB_DUAL   = 3;
   localparam int CB_WB_OFF = 4;

   typedef struct packed {
      logic wb_off;
      logic dual;
      logic offset;
      logic clip;
   } sumfmt_mode_t;

   function automatic sumfmt_mode_t decode_mode(input logic [CTRL_W-1:0] cw);
      sumfmt_mode_t m;
      m.clip   = cw[CB_CLIP];
      m.offset = cw[CB_OFFSET];
      m.dual   = cw[CB_DUAL];
      m.wb_off = cw[CB_WB_OFF];
      return m;
   endfunction
endpackage

// File: rtl/sumfmt_adder.sv
module sumfmt_adder #(
   parameter int IN_W  = 18,
   parameter int N_IN  = 5,
   parameter int ACC_W = 21
) (
   input  logic [N_IN*IN_W-1:0]    terms,
   input  logic [N_IN-1:0]         term_en,
   output logic signed [ACC_W-1:0] total
);
   if (ACC_W < IN_W) begin : g_bad_w
      $error("sumfmt_adder: ACC_W must be at least IN_W");
   end

   logic signed [ACC_W-1:0] partial [N_IN+1];
   assign partial[0] = '0;

   for (genvar i = 0; i < N_IN; i++) begin : g_term
      logic signed [ACC_W-1:0] ext;
      assign ext = ACC_W'($signed(terms[i*IN_W +: IN_W]));
      assign partial[i+1] = partial[i] + (term_en[i] ? ext : '0);
   end

   assign total = partial[N_IN];
endmodule

// File: rtl/sumfmt_limiter.sv
module sumfmt_limiter #(
   parameter int ACC_W = 21,
   parameter int OUT_W = 18
) (
   input  logic signed [ACC_W-1:0] acc_in,
   input  logic                    clip_en,
   output logic [OUT_W-1:0]        lim_out
);
   if (OUT_W > ACC_W) begin : g_bad_w
      $error("sumfmt_limiter: OUT_W must not exceed ACC_W");
   end

   if (ACC_W == OUT_W) begin : g_pass
      logic unused_clip;
      assign unused_clip = clip_en;
      assign lim_out     = acc_in;
   end else begin : g_sat
      localparam int TOP_W = ACC_W - OUT_W + 1;
      logic [TOP_W-1:0] top_bits;
      logic             over;
      assign top_bits = acc_in[ACC_W-1:OUT_W-1];
      assign over     = !((&top_bits) || !(|top_bits));
      always_comb begin
         if (clip_en && over) begin
            lim_out = acc_in[ACC_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                      : {1'b0, {(OUT_W-1){1'b1}}};
         end else begin
            lim_out = acc_in[OUT_W-1:0];
         end
      end
   end
endmodule

// File: rtl/sumfmt_encoder.sv
module sumfmt_encoder #(
   parameter int OUT_W = 18
) (
   input  logic [OUT_W-1:0] val_in,
   input  logic             offset_en,
   output logic [OUT_W-1:0] enc_out
);
   if (OUT_W < 2) begin : g_bad_w
      $error("sumfmt_encoder: OUT_W must be at least 2");
   end
   assign enc_out = {val_in[OUT_W-1] ^ offset_en, val_in[OUT_W-2:0]};
endmodule

// File: rtl/chan_sum_formatter.sv
module chan_sum_formatter
   import sumfmt_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int SAMPLE_W = 18,
   parameter int OUT_W    = 18,
   parameter int GUARD_W  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [CTRL_W-1:0]          ctrl_word,
   input  logic [NUM_CH*SAMPLE_W-1:0] ch_data,
   input  logic [SAMPLE_W-1:0]        wb_data,
   output logic [OUT_W-1:0]           dout_a,
   output logic [OUT_W-1:0]           dout_b
);
   localparam int ACC_W  = SAMPLE_W + GUARD_W;
   localparam int HALF   = NUM_CH / 2;
   localparam int UPPER  = NUM_CH - HALF;
   localparam int N_A    = NUM_CH + 1;
   localparam int LANES  = 2;
   localparam logic signed [ACC_W-1:0] SAT_MAX = ACC_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] SAT_MIN = -SAT_MAX - ACC_W'(1);

   if (NUM_CH < 2 || (NUM_CH % 2) != 0) begin : g_bad_ch
      $error("chan_sum_formatter: NUM_CH must be even and at least 2");
   end
   if (GUARD_W < $clog2(NUM_CH + 2)) begin : g_bad_guard
      $error("chan_sum_formatter: GUARD_W too small for NUM_CH plus wideband");
   end
   if (OUT_W > ACC_W || OUT_W < 2) begin : g_bad_out
      $error("chan_sum_formatter: OUT_W out of range");
   end

   sumfmt_mode_t mode;
   assign mode = decode_mode(ctrl_word);

   // Lane A term set: all channels then the wideband sample
   logic [N_A*SAMPLE_W-1:0] terms_a;
   logic [N_A-1:0]          en_a;
   assign terms_a = {wb_data, ch_data};

   for (genvar i = 0; i < N_A; i++) begin : g_en_a
      if (i < HALF) begin : g_low
         assign en_a[i] = 1'b1;
      end else if (i < NUM_CH) begin : g_high
         assign en_a[i] = !mode.dual;
      end else begin : g_wb
         assign en_a[i] = !mode.wb_off;
      end
   end

   logic signed [ACC_W-1:0] lane_sum [LANES];

   sumfmt_adder #(.IN_W(SAMPLE_W), .N_IN(N_A), .ACC_W(ACC_W)) u_add_a (
      .terms   (terms_a),
      .term_en (en_a),
      .total   (lane_sum[0])
   );

   sumfmt_adder #(.IN_W(SAMPLE_W), .N_IN(UPPER), .ACC_W(ACC_W)) u_add_b (
      .terms   (ch_data[NUM_CH*SAMPLE_W-1:HALF*SAMPLE_W]),
      .term_en ({UPPER{1'b1}}),
      .total   (lane_sum[1])
   );

   logic [OUT_W-1:0] lane_fmt [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [OUT_W-1:0] lim;
      sumfmt_limiter #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_lim (
         .acc_in  (lane_sum[l]),
         .clip_en (mode.clip),
         .lim_out (lim)
      );
      sumfmt_encoder #(.OUT_W(OUT_W)) u_enc (
         .val_in    (lim),
         .offset_en (mode.offset),
         .enc_out   (lane_fmt[l])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_a <= '0;
         dout_b <= '0;
      end else begin
         dout_a <= lane_fmt[0];
         dout_b <= mode.dual ? lane_fmt[1] : '0;
      end
   end

   AST_SECOND_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_word[CB_DUAL] |=> dout_b == '0); // R8
   AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[CB_CLIP] && !ctrl_word[CB_OFFSET] && lane_sum[0] > SAT_MAX)
      |=> dout_a == SAT_MAX[OUT_W-1:0]); // R5
   AST_CLIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[CB_CLIP] && !ctrl_word[CB_OFFSET] && lane_sum[0] < SAT_MIN)
      |=> dout_a == SAT_MIN[OUT_W-1:0]); // R5
   AST_WRAP_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_word[CB_CLIP] && !ctrl_word[CB_OFFSET])
      |=> dout_a == $past(lane_sum[0][OUT_W-1:0])); // R4
   AST_OFFSET_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_word[CB_CLIP] && ctrl_word[CB_OFFSET])
      |=> dout_a == {~$past(lane_sum[0][OUT_W-1]), $past(lane_sum[0][OUT_W-2:0])}); // R6
endmodule

// File: tb/chan_sum_formatter_tb.sv
`timescale 1ns/1ps
module chan_sum_formatter_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [6:0]  ctrl_word;
   logic [71:0] ch_data;
   logic [17:0] wb_data;
   logic [17:0] dout_a, dout_b;

   int ch_i [4];
   int wb_i;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [17:0] exp_a, exp_b;
   string tag_a, tag_b;

   always #2.5 clk = ~clk;

   assign ch_data = {18'(ch_i[3]), 18'(ch_i[2]), 18'(ch_i[1]), 18'(ch_i[0])};
   assign wb_data = 18'(wb_i);

   chan_sum_formatter u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ch_data(ch_data),
      .wb_data(wb_data), .dout_a(dout_a), .dout_b(dout_b)
   );

   function automatic logic [17:0] fmt(int s, bit clip, bit offs);
      int v;
      logic [17:0] r;
      v = s;
      if (clip) begin
         if (v > 131071) v = 131071;
         if (v < -131072) v = -131072;
      end
      r = v[17:0];
      if (offs) r[17] = ~r[17];
      return r;
   endfunction

   task automatic chk(string tag, string port, logic [17:0] act, logic [17:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s port %s actual %h expected %h", tag, port, act, exp);
      end
   endtask

   task automatic step(string tag, int cw, int a, int b, int c, int d, int wb);
      int s;
      bit dual;
      @(negedge clk);
      chk(tag_a, "A", dout_a, exp_a);
      chk(tag_b, "B", dout_b, exp_b);
      ctrl_word = 7'(cw);
      ch_i[0] = a; ch_i[1] = b; ch_i[2] = c; ch_i[3] = d; wb_i = wb;
      dual = cw[3];
      s = a + b + (dual ? 0 : c + d) + (cw[4] ? 0 : wb);
      exp_a = fmt(s, cw[0], cw[1]);
      exp_b = dual ? fmt(c + d, cw[0], cw[1]) : 18'h0;
      tag_a = tag;
      tag_b = dual ? tag : "R8";
   endtask

   initial begin
      rst_n = 1'b0; ctrl_word = '0; wb_i = 0;
      foreach (ch_i[k]) ch_i[k] = 0;
      exp_a = '0; exp_b = '0; tag_a = "R1"; tag_b = "R1";
      repeat (3) @(negedge clk);
      chk("R1", "A", dout_a, 18'h0);
      chk("R1", "B", dout_b, 18'h0);
      ctrl_word = 7'h13; ch_i[0] = 5000; wb_i = 77;
      @(negedge clk);
      chk("R1", "A", dout_a, 18'h0);
      ctrl_word = '0; ch_i[0] = 0; wb_i = 0;
      rst_n = 1'b1;
      // R2 basic sums, wideband off
      step("R2", 'h10, 100, 200, -50, 7, 999);
      step("R2", 'h10, -1, -2, -3, -4, 5);
      step("R2", 'h10, 131071, -131072, 0, 1, 0);
      // R3 wideband gating
      step("R3", 'h00, 10, 20, 30, 40, 1000);
      step("R3", 'h10, 10, 20, 30, 40, 1000);
      step("R3", 'h00, 0, 0, 0, 0, -131072);
      step("R3", 'h10, 0, 0, 0, 0, -131072);
      // R4 wrap on overflow
      step("R4", 'h00, 131071, 131071, 131071, 131071, 131071);
      step("R4", 'h10, -131072, -131072, -131072, -131072, 0);
      step("R4", 'h10, 70000, 70000, 0, 0, 0);
      // R5 clip
      step("R5", 'h01, 131071, 131071, 131071, 131071, 131071);
      step("R5", 'h11, -131072, -131072, -131072, -131072, 0);
      step("R5", 'h11, 70000, 70000, 0, 0, 0);
      step("R5", 'h11, 1234, -567, 89, -10, 0);
      step("R5", 'h01, 131071, 0, 0, 0, 1);
      // R6 offset binary
      step("R6", 'h12, 0, 0, 0, 0, 0);
      step("R6", 'h12, -5, 0, 0, 0, 0);
      step("R6", 'h13, 131071, 131071, 0, 0, 0);
      step("R6", 'h13, -131072, -131072, 0, 0, 0);
      step("R6", 'h02, 100, 0, 0, 0, 131071);
      // R7 dual output
      step("R7", 'h18, 1, 2, 3, 4, 500);
      step("R7", 'h08, 1, 2, 3, 4, 500);
      step("R7", 'h09, 131071, 131071, -131072, -131072, 0);
      step("R7", 'h0A, -7, 3, 100000, 100000, 0);
      step("R7", 'h0B, 0, 0, 131071, 5, -9);
      // R8 second bus clears after dual turns off
      step("R8", 'h10, 1, 2, 3, 4, 0);
      step("R7", 'h08, 9, 9, 9, 9, 9);
      step("R8", 'h00, 9, 9, 9, 9, 9);
      // R9 reserved bits ignored
      step("R9", 'h74, 131071, 131071, 131071, 131071, 0);
      step("R9", 'h65, 131071, 131071, 131071, 131071, 0);
      step("R9", 'h6E, 50, -60, 70, -80, 90);
      step("R9", 'h04, -3, -3, -3, -3, -3);
      // random mix
      for (int n = 0; n < 300; n++) begin
         step("R2", int'($urandom_range(127)),
              int'($urandom_range(262143)) - 131072, int'($urandom_range(262143)) - 131072,
              int'($urandom_range(262143)) - 131072, int'($urandom_range(262143)) - 131072,
              int'($urandom_range(262143)) - 131072);
      end
      step("R2", 'h10, 0, 0, 0, 0, 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule